// File: doc/BRIEF.md
# Transmit Queue Teardown Controller

This block manages the orderly shutdown of a single descriptor-based transmit message queue. Software requests shutdown by writing a one to a command bit. From the next cycle on, no new message may start. A message that is already in progress may send its remaining segments, unless an error response has arrived for it. An error response stops the message at once. The block counts segments that have been sent but not yet answered. Responses carry no ordering, so the count does not care which segment each one answers.

Once no message is active and the outstanding count is zero, the controller chooses one of two ways to finish. The choice depends on the `q_has_desc` input at that moment:

- **Descriptor present.** The controller requests a write of the teardown flag into the descriptor addressed by the head pointer. It then clears the head pointer, loads the completion pointer with the sentinel `0xFFFFFFFC`, and raises the queue interrupt.
- **No descriptor.** Nothing is written, and no interrupt is raised.

In both cases hardware clears the command bit. The queue then stays halted until software writes the head pointer again.

The controller has five states:

- `TD_IDLE`: normal operation. It moves to `TD_DRAIN` when the command bit is set.
- `TD_DRAIN`: waits until the active message is finished. It moves to `TD_WAIT_RESP` when no message is active.
- `TD_WAIT_RESP`: waits for the outstanding count to reach zero. It then moves to `TD_MARK_DESC` if a descriptor is present, or to `TD_FINISH` if not.
- `TD_MARK_DESC`: holds the descriptor write request. It moves to `TD_FINISH` on acknowledge.
- `TD_FINISH`: lasts exactly one cycle. It clears the command bit, halts the queue, and (on the descriptor path) retires the pointers and pulses the interrupt. It then moves to `TD_IDLE`.

Top module: `txq_td_ctrl`

## Requirements
- R1: A register write with `reg_wr_sel`=0 and `reg_wr_data[0]`=1 sets `td_cmd` from the next cycle. While `td_cmd` is 1, `msg_start_ok` is 0. A write of 0 to this bit has no effect.
- R2: A message starts when `msg_start_req` and `msg_start_ok` are both 1 on a clock edge. From the next cycle `seg_send_ok` is 1, and it stays 1 until a segment is sent with `seg_last`=1. This holds even after teardown has been requested.
- R3: A response with `resp_err`=1 for the active message drives `seg_send_ok` to 0 from the next cycle, so no further segments are sent.
- R4: The outstanding count rises by one on `seg_sent`, falls by one on `resp_valid` (OK or error), and is unchanged when both fall in the same cycle. Teardown never completes while the count is non-zero or a message is active.
- R5: If `q_has_desc` is 1 when the responses drain, `desc_wr_req` is raised with `desc_wr_addr` equal to the head pointer, and is held until `desc_wr_ack`. In the following FINISH cycle `q_irq` is 1 for exactly one cycle. From the next cycle `head_ptr` is 0 and `compl_ptr` is `0xFFFFFFFC`.
- R6: If `q_has_desc` is 0 when the responses drain, no descriptor write is requested, `q_irq` stays 0, and `head_ptr` and `compl_ptr` keep their values.
- R7: On both completion paths, `td_cmd` reads 0 from the cycle after FINISH.
- R8: After completion, `q_halted` is 1 and `msg_start_ok` is 0. A register write with `reg_wr_sel`=1 loads `head_ptr` and clears `q_halted`. A write with `reg_wr_sel`=2 loads `compl_ptr`.
- R9: The outstanding count never wraps past its all-ones value and never decrements below zero.
- R10: After reset, `head_ptr`=0, `compl_ptr`=0, `td_cmd`=0, `q_halted`=0, `q_irq`=0, `desc_wr_req`=0 and `msg_start_ok`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select: 0 command, 1 head pointer, 2 completion pointer |
| reg_wr_data | input | ADDR_W | Register write data |
| msg_start_req | input | 1 | Transmitter asks to begin a new message |
| msg_start_ok | output | 1 | A new message may begin this cycle |
| seg_send_ok | output | 1 | The active message may send a segment |
| seg_sent | input | 1 | One segment was sent |
| seg_last | input | 1 | The segment sent is the last of its message |
| resp_valid | input | 1 | A response for some in-flight segment arrived |
| resp_err | input | 1 | The arriving response is an error |
| q_has_desc | input | 1 | The queue holds a next descriptor |
| desc_wr_req | output | 1 | Request to write the teardown flag into a descriptor |
| desc_wr_addr | output | ADDR_W | Address of the descriptor to mark |
| desc_wr_ack | input | 1 | Descriptor write accepted |
| q_irq | output | 1 | Queue interrupt pulse |
| td_cmd | output | 1 | Teardown command bit |
| head_ptr | output | ADDR_W | Head descriptor pointer register |
| compl_ptr | output | ADDR_W | Completion pointer register |
| q_halted | output | 1 | Queue halted after a teardown |

## Verification
A segment send and a response can land on the same clock edge. The count must then stay unchanged, and the controller must still refuse to finish while answers are owed. The bench provokes this by sending the second segment of each multi-segment message in the same cycle as the response to the first.

It judges the collision by what happens afterwards. It holds back one final response for several cycles and checks that `td_cmd` stays set with no descriptor request and no interrupt. Only after that final response may completion appear. The bench sweeps segment count, error versus clean response, and descriptor present versus absent, and computes the expected pointer values from the scenario index.

// File: rtl/txq_td_pkg.sv
package txq_td_pkg;

    typedef enum logic [2:0] {
        TD_IDLE,
        TD_DRAIN,
        TD_WAIT_RESP,
        TD_MARK_DESC,
        TD_FINISH
    } td_state_t;

    localparam logic [1:0] SEL_CMD   = 2'd0;
    localparam logic [1:0] SEL_HEAD  = 2'd1;
    localparam logic [1:0] SEL_COMPL = 2'd2;

endpackage

// File: rtl/txq_td_inflight.sv
module txq_td_inflight #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_fire,
    input  logic             seg_sent,
    input  logic             seg_last,
    input  logic             resp_valid,
    input  logic             resp_err,
    output logic             msg_active,
    output logic [CNT_W-1:0] outstanding,
    output logic             cnt_zero
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assign cnt_zero = (outstanding == '0);

    // Message activity: ends on the last segment or on an error response.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg_active <= 1'b0;
        end else if (start_fire) begin
            msg_active <= 1'b1;
        end else if (resp_valid && resp_err) begin
            msg_active <= 1'b0;
        end else if (seg_sent && seg_last) begin
            msg_active <= 1'b0;
        end
    end

    // Order-free in-flight segment count.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outstanding <= '0;
        end else begin
            unique case ({seg_sent, resp_valid})
                2'b10:   outstanding <= outstanding + 1'b1;
                2'b01:   outstanding <= outstanding - 1'b1;
                default: outstanding <= outstanding;
            endcase
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_sent && !resp_valid) |-> (outstanding != CNT_MAX));

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !seg_sent) |-> !cnt_zero);

    // R4
    same_cycle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_sent && resp_valid) |=> $stable(outstanding));

    // R3
    err_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err && !start_fire) |=> !msg_active);

endmodule

// File: rtl/txq_td_regs.sv
module txq_td_regs
    import txq_td_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              hw_clr_cmd,
    input  logic              hw_retire,
    input  logic              hw_halt,
    output logic [ADDR_W-1:0] head_ptr,
    output logic [ADDR_W-1:0] compl_ptr,
    output logic              td_cmd,
    output logic              halted
);
    localparam logic [ADDR_W-1:0] DONE_PTR = {{(ADDR_W-2){1'b1}}, 2'b00};

    logic wr_cmd, wr_head, wr_compl;

    assign wr_cmd   = wr_en && (wr_sel == SEL_CMD);
    assign wr_head  = wr_en && (wr_sel == SEL_HEAD);
    assign wr_compl = wr_en && (wr_sel == SEL_COMPL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_ptr  <= '0;
            compl_ptr <= '0;
            td_cmd    <= 1'b0;
            halted    <= 1'b0;
        end else begin
            if (hw_retire) begin
                head_ptr <= '0;
            end else if (wr_head) begin
                head_ptr <= wr_data;
            end

            if (hw_retire) begin
                compl_ptr <= DONE_PTR;
            end else if (wr_compl) begin
                compl_ptr <= wr_data;
            end

            if (hw_clr_cmd) begin
                td_cmd <= 1'b0;
            end else if (wr_cmd && wr_data[0]) begin
                td_cmd <= 1'b1;
            end

            if (hw_halt) begin
                halted <= 1'b1;
            end else if (wr_head) begin
                halted <= 1'b0;
            end
        end
    end

    // R7
    cmd_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_clr_cmd |=> !td_cmd);

    // R5
    retire_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_retire |=> (head_ptr == '0) && (compl_ptr == DONE_PTR));

endmodule

// File: rtl/txq_td_fsm.sv
module txq_td_fsm
    import txq_td_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic td_cmd,
    input  logic msg_active,
    input  logic cnt_zero,
    input  logic q_has_desc,
    input  logic desc_wr_ack,
    output logic in_idle,
    output logic desc_wr_req,
    output logic hw_clr_cmd,
    output logic hw_retire,
    output logic hw_halt,
    output logic q_irq
);
    td_state_t state_q, state_d;
    logic      mark_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Remembers which completion path was chosen.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mark_q <= 1'b0;
        end else if (state_q == TD_WAIT_RESP && cnt_zero) begin
            mark_q <= q_has_desc;
        end else if (state_q == TD_IDLE) begin
            mark_q <= 1'b0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TD_IDLE:      if (td_cmd) state_d = TD_DRAIN;
            TD_DRAIN:     if (!msg_active) state_d = TD_WAIT_RESP;
            TD_WAIT_RESP: if (cnt_zero) state_d = q_has_desc ? TD_MARK_DESC : TD_FINISH;
            TD_MARK_DESC: if (desc_wr_ack) state_d = TD_FINISH;
            TD_FINISH:    state_d = TD_IDLE;
            default:      state_d = TD_IDLE;
        endcase
    end

    always_comb begin
        in_idle     = (state_q == TD_IDLE);
        desc_wr_req = (state_q == TD_MARK_DESC);
        hw_clr_cmd  = (state_q == TD_FINISH);
        hw_halt     = (state_q == TD_FINISH);
        hw_retire   = (state_q == TD_FINISH) && mark_q;
        q_irq       = (state_q == TD_FINISH) && mark_q;
    end

    // R4
    finish_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TD_FINISH) |-> (cnt_zero && !msg_active));

    // R5
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_wr_req && !desc_wr_ack) |=> desc_wr_req);

    // R5
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_irq |=> !q_irq);

endmodule

// File: rtl/txq_td_ctrl.sv
module txq_td_ctrl #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_sel,
    input  logic [ADDR_W-1:0] reg_wr_data,
    input  logic              msg_start_req,
    output logic              msg_start_ok,
    output logic              seg_send_ok,
    input  logic              seg_sent,
    input  logic              seg_last,
    input  logic              resp_valid,
    input  logic              resp_err,
    input  logic              q_has_desc,
    output logic              desc_wr_req,
    output logic [ADDR_W-1:0] desc_wr_addr,
    input  logic              desc_wr_ack,
    output logic              q_irq,
    output logic              td_cmd,
    output logic [ADDR_W-1:0] head_ptr,
    output logic [ADDR_W-1:0] compl_ptr,
    output logic              q_halted
);
    logic             msg_active, cnt_zero, in_idle, start_fire;
    logic             hw_clr_cmd, hw_retire, hw_halt;
    logic [CNT_W-1:0] outstanding;

    assign msg_start_ok = in_idle && !td_cmd && !q_halted && !msg_active;
    assign start_fire   = msg_start_req && msg_start_ok;
    assign seg_send_ok  = msg_active;
    assign desc_wr_addr = head_ptr;

    txq_td_inflight #(.CNT_W(CNT_W)) i_inflight (
        .clk(clk), .rst_n(rst_n), .start_fire(start_fire),
        .seg_sent(seg_sent), .seg_last(seg_last),
        .resp_valid(resp_valid), .resp_err(resp_err),
        .msg_active(msg_active), .outstanding(outstanding), .cnt_zero(cnt_zero)
    );

    txq_td_regs #(.ADDR_W(ADDR_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_sel(reg_wr_sel),
        .wr_data(reg_wr_data), .hw_clr_cmd(hw_clr_cmd), .hw_retire(hw_retire),
        .hw_halt(hw_halt), .head_ptr(head_ptr), .compl_ptr(compl_ptr),
        .td_cmd(td_cmd), .halted(q_halted)
    );

    txq_td_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .td_cmd(td_cmd), .msg_active(msg_active),
        .cnt_zero(cnt_zero), .q_has_desc(q_has_desc), .desc_wr_ack(desc_wr_ack),
        .in_idle(in_idle), .desc_wr_req(desc_wr_req), .hw_clr_cmd(hw_clr_cmd),
        .hw_retire(hw_retire), .hw_halt(hw_halt), .q_irq(q_irq)
    );

    // R1
    no_start_in_td_chk: assert property (@(posedge clk) disable iff (!rst_n)
        td_cmd |-> !msg_start_ok);

    // R8
    halted_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_halted |-> !msg_start_ok);

    // R6
    quiet_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_clr_cmd && !q_irq && !reg_wr_en) |=> ($stable(head_ptr) && $stable(compl_ptr)));

endmodule

// File: tb/test_txq_td_ctrl.sv
module test_txq_td_ctrl;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic [1:0]        reg_wr_sel = '0;
    logic [ADDR_W-1:0] reg_wr_data = '0;
    logic              msg_start_req = 1'b0;
    logic              msg_start_ok, seg_send_ok;
    logic              seg_sent = 1'b0, seg_last = 1'b0;
    logic              resp_valid = 1'b0, resp_err = 1'b0;
    logic              q_has_desc = 1'b0;
    logic              desc_wr_req;
    logic [ADDR_W-1:0] desc_wr_addr;
    logic              desc_wr_ack = 1'b0;
    logic              q_irq, td_cmd, q_halted;
    logic [ADDR_W-1:0] head_ptr, compl_ptr;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    txq_td_ctrl #(.ADDR_W(ADDR_W), .CNT_W(4)) i_txq_td_ctrl (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic send_seg(input bit last, input bit with_resp);
        seg_sent = 1'b1; seg_last = last; resp_valid = with_resp; resp_err = 1'b0;
        tick();
        seg_sent = 1'b0; seg_last = 1'b0; resp_valid = 1'b0;
    endtask

    task automatic respond(input bit err);
        resp_valid = 1'b1; resp_err = err;
        tick();
        resp_valid = 1'b0; resp_err = 1'b0;
    endtask

    task automatic run_case(input int idx, input int nseg, input bit err, input bit has_desc);
        logic [31:0] head_exp, compl_exp;
        int req_cycles, irq_cnt, pending;
        head_exp  = 32'h0000_0100 + 32'(idx) * 32'h10;
        compl_exp = 32'h0000_00A5 + 32'(idx);
        reg_write(2'd1, head_exp);
        reg_write(2'd2, compl_exp);
        q_has_desc = has_desc;
        chk(msg_start_ok == 1'b1, "R8", "start allowed after head write", 32'(msg_start_ok), 1);
        msg_start_req = 1'b1;
        tick();
        msg_start_req = 1'b0;
        chk(seg_send_ok == 1'b1, "R2", "message active after start", 32'(seg_send_ok), 1);
        send_seg(nseg == 1, 1'b0);
        reg_write(2'd0, 32'h1);
        chk(td_cmd == 1'b1, "R1", "command bit set", 32'(td_cmd), 1);
        chk(msg_start_ok == 1'b0, "R1", "start blocked", 32'(msg_start_ok), 0);
        pending = 1;
        if (!err && nseg > 1) begin
            chk(seg_send_ok == 1'b1, "R2", "started message continues", 32'(seg_send_ok), 1);
            // second segment collides with the first response
            send_seg(nseg == 2, 1'b1);
            for (int s = 3; s <= nseg; s++) send_seg(s == nseg, 1'b0);
            pending = nseg - 1;
            chk(seg_send_ok == 1'b0, "R2", "message ended on last segment", 32'(seg_send_ok), 0);
            while (pending > 1) begin respond(1'b0); pending--; end
        end
        for (int w = 0; w < 3; w++) tick();
        chk(td_cmd == 1'b1 && !desc_wr_req && !q_irq, "R4", "no completion while owed",
            {29'd0, td_cmd, desc_wr_req, q_irq}, 32'h4);
        respond(err);
        if (err && nseg > 1)
            chk(seg_send_ok == 1'b0, "R3", "error stops segments", 32'(seg_send_ok), 0);
        req_cycles = 0; irq_cnt = 0;
        for (int c = 0; c < 12; c++) begin
            if (desc_wr_req) begin
                req_cycles++;
                chk(desc_wr_addr == head_exp, "R5", "descriptor address", desc_wr_addr, head_exp);
            end
            if (q_irq) irq_cnt++;
            desc_wr_ack = desc_wr_req && (req_cycles >= 2);
            tick();
        end
        desc_wr_ack = 1'b0;
        if (has_desc) begin
            chk(req_cycles == 2, "R5", "descriptor request cycles", 32'(req_cycles), 2);
            chk(irq_cnt == 1, "R5", "interrupt pulses", 32'(irq_cnt), 1);
            chk(head_ptr == 32'h0, "R5", "head cleared", head_ptr, 0);
            chk(compl_ptr == 32'hFFFF_FFFC, "R5", "completion sentinel", compl_ptr, 32'hFFFF_FFFC);
        end else begin
            chk(req_cycles == 0, "R6", "no descriptor request", 32'(req_cycles), 0);
            chk(irq_cnt == 0, "R6", "no interrupt", 32'(irq_cnt), 0);
            chk(head_ptr == head_exp, "R6", "head kept", head_ptr, head_exp);
            chk(compl_ptr == compl_exp, "R6", "completion kept", compl_ptr, compl_exp);
        end
        chk(td_cmd == 1'b0, "R7", "command bit cleared", 32'(td_cmd), 0);
        chk(q_halted == 1'b1 && msg_start_ok == 1'b0, "R8", "queue halted",
            {30'd0, q_halted, msg_start_ok}, 32'h2);
        // a zero command write must not restart teardown
        reg_write(2'd0, 32'h0);
        chk(td_cmd == 1'b0, "R1", "zero command write ignored", 32'(td_cmd), 0);
    endtask

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int idx;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R10
        chk(head_ptr == 0 && compl_ptr == 0, "R10", "pointers after reset", head_ptr | compl_ptr, 0);
        chk(!td_cmd && !q_halted && !q_irq && !desc_wr_req, "R10", "flags after reset",
            {28'd0, td_cmd, q_halted, q_irq, desc_wr_req}, 0);
        chk(msg_start_ok == 1'b1, "R10", "start allowed after reset", 32'(msg_start_ok), 1);
        idx = 0;
        for (int n = 1; n <= 3; n++)
            for (int e = 0; e < 2; e++)
                for (int d = 0; d < 2; d++) begin
                    run_case(idx, n, e[0], d[0]);
                    idx++;
                end
        // R9: counter climbs to 9 and returns to zero with interleaved answers
        reg_write(2'd1, 32'h40);
        msg_start_req = 1'b1; tick(); msg_start_req = 1'b0;
        for (int s = 1; s <= 9; s++) send_seg(s == 9, 1'b0);
        reg_write(2'd0, 32'h1);
        q_has_desc = 1'b0;
        for (int s = 0; s < 8; s++) respond(s[0]);
        for (int w = 0; w < 3; w++) tick();
        chk(td_cmd == 1'b1, "R9", "one answer still owed", 32'(td_cmd), 1);
        respond(1'b0);
        for (int w = 0; w < 4; w++) tick();
        chk(td_cmd == 1'b0, "R9", "drained after last answer", 32'(td_cmd), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule